// File: doc/BRIEF.md
# Word-Packing FIFO Adapter

This block sits between a 32-bit data port and two byte-wide FIFOs that feed and drain a serial shift engine. In byte mode, each port write queues one byte and each port read returns one byte. In word mode, which a DMA engine uses, a port write is split into up to four bytes for transmission. A port read gathers up to four received bytes into one word.

A 16-bit length value, loaded before a word-mode transfer, sets how many bytes the transfer moves. Only the last word may be partial. Two budgets derived from the length decide how many lanes of that last word are valid on each side. A live byte counter falls by one each time the engine completes a byte. Completion is flagged when that counter and the transmit queue are both empty.

Request outputs pace the DMA engine. The transmit request asks for a word while space remains. The receive request asks for a read when a full word, or the final tail of the transfer, is waiting.

Top module: `pk_word_packer`

## Requirements
- R1: After reset, `len_left` is 0, `done` is 1, `tx_avail` is 0, `rx_room` is 1, both requests are 0 and `port_rdata` is 0.
- R2: With `wide_mode` low, a port write queues only bits 7:0 as one byte. The value on `port_rdata` is the oldest received byte in bits 7:0, with bits 31:8 zero, and a port read removes one byte.
- R3: With `wide_mode` high, a port write queues min(4, tx budget) bytes, taking bits 7:0 first, then 15:8, 23:16 and 31:24. The tx budget is set to the loaded length and falls by each byte queued in word mode. A word-mode write with a budget of 0 queues nothing.
- R4: With `wide_mode` high, `port_rdata` carries n = min(4, rx budget, bytes held) bytes, the oldest in bits 7:0 and the unused upper lanes zero. A read removes exactly n bytes. The rx budget is set to the loaded length and falls by each byte read in word mode.
- R5: A port write whose byte count exceeds the free transmit space is dropped whole. An `rx_push` while `rx_room` is low is dropped and does not change `len_left`.
- R6: `len_wr` loads `len_left` from `len_val`. Otherwise each accepted `rx_push` lowers `len_left` by one, and the count stays at 0 once it gets there. A load in the same cycle as a push takes priority.
- R7: `done` is high exactly when `len_left` is 0 and the transmit queue is empty.
- R8: `tx_dreq` is high when in word mode, the tx budget is nonzero and at least 4 transmit slots are free. `rx_dreq` is high when in word mode, the rx budget is nonzero and the bytes held reach min(4, rx budget). Both requests are low in byte mode.
- R9: `clr_tx` empties the transmit queue and `clr_rx` empties the receive queue, both by the next cycle. Any change of `wide_mode` empties both queues. A port write in the same cycle as a transmit flush is dropped.
- R10: The following pairs may happen in the same cycle, and both operations take effect: a port write with a serial take, and an `rx_push` with a port read. Whether the write or push is accepted depends on the queue occupancy before that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| wide_mode | input | 1 | 1 = 32-bit word access, 0 = byte access |
| len_wr | input | 1 | Load transfer length |
| len_val | input | 16 | Transfer length in bytes |
| clr_tx | input | 1 | Flush transmit queue |
| clr_rx | input | 1 | Flush receive queue |
| port_wr | input | 1 | Data port write strobe |
| port_wdata | input | 32 | Data port write value |
| port_rd | input | 1 | Data port read strobe |
| port_rdata | output | 32 | Value a read returns this cycle |
| tx_avail | output | 1 | Transmit queue holds a byte |
| tx_byte | output | 8 | Oldest transmit byte |
| tx_take | input | 1 | Engine takes the oldest transmit byte |
| rx_push | input | 1 | Engine delivers a completed byte |
| rx_byte | input | 8 | Completed byte |
| rx_room | output | 1 | Receive queue can accept a byte |
| tx_dreq | output | 1 | Transmit DMA request |
| rx_dreq | output | 1 | Receive DMA request |
| len_left | output | 16 | Bytes not yet completed serially |
| done | output | 1 | Transfer complete |

## Verification
Two pairs of operations can share a clock cycle. On the transmit side, a port write can coincide with the engine taking a byte. On the receive side, an engine push can coincide with a port read. The bench drives each pair on the same falling edge and checks the byte order and the surviving occupancy through the scoreboard queue. It also sends the write to a full queue while a take frees a slot. The write must still be dropped, because acceptance is judged on the occupancy before the cycle. A length load that lands on the same edge as an accepted push is judged by the loaded value winning.

// File: rtl/pk_pkg.sv
package pk_pkg;
    localparam int LANES = 4;
    typedef logic [7:0] byte_t;

    function automatic logic [2:0] lane_cap(input int avail);
        return (avail >= LANES) ? 3'(LANES) : 3'(avail);
    endfunction
endpackage

// File: rtl/pk_lane_fifo.sv
module pk_lane_fifo
    import pk_pkg::*;
#(
    parameter int DEPTH     = 16,
    parameter int IN_LANES  = 4,
    parameter int OUT_LANES = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          flush,
    input  logic [2:0]                    push_n,
    input  logic [IN_LANES-1:0][7:0]      push_data,
    input  logic [2:0]                    pop_n,
    output logic [OUT_LANES-1:0][7:0]     peek,
    output logic [$clog2(DEPTH):0]        count
);
    localparam int AW = $clog2(DEPTH);

    typedef struct packed {
        logic [AW-1:0] wp;
        logic [AW-1:0] rp;
        logic [AW:0]   cnt;
    } fifo_st_t;

    fifo_st_t st_d, st_q;
    byte_t    mem [DEPTH];

    always_comb begin
        st_d = st_q;
        if (flush) begin
            st_d = '0;
        end else begin
            st_d.wp  = st_q.wp + AW'(push_n);
            st_d.rp  = st_q.rp + AW'(pop_n);
            st_d.cnt = st_q.cnt + (AW+1)'(push_n) - (AW+1)'(pop_n);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < IN_LANES; i++) begin
            if (!flush && 3'(i) < push_n)
                mem[st_q.wp + AW'(i)] <= push_data[i];
        end
    end

    for (genvar g = 0; g < OUT_LANES; g++) begin : g_peek
        assign peek[g] = mem[st_q.rp + AW'(g)];
    end

    assign count = st_q.cnt;

    p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !flush |-> (int'(st_q.cnt) + int'(push_n) <= DEPTH));
    p_no_underflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !flush |-> (int'(pop_n) <= int'(st_q.cnt)));
    p_flush_empties_r9: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (count == '0));
endmodule

// File: rtl/pk_len_track.sv
module pk_len_track #(
    parameter int LW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [LW-1:0] load_val,
    input  logic          byte_done,
    input  logic [2:0]    tx_used,
    input  logic [2:0]    rx_used,
    output logic [LW-1:0] len_left,
    output logic [LW-1:0] tx_budget,
    output logic [LW-1:0] rx_budget
);
    typedef struct packed {
        logic [LW-1:0] len;
        logic [LW-1:0] txb;
        logic [LW-1:0] rxb;
    } len_st_t;

    len_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load) begin
            st_d.len = load_val;
            st_d.txb = load_val;
            st_d.rxb = load_val;
        end else begin
            if (byte_done && st_q.len != '0) st_d.len = st_q.len - 1'b1;
            st_d.txb = st_q.txb - LW'(tx_used);
            st_d.rxb = st_q.rxb - LW'(rx_used);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign len_left  = st_q.len;
    assign tx_budget = st_q.txb;
    assign rx_budget = st_q.rxb;

    p_len_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (len_left == $past(load_val)));
    p_len_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && byte_done && len_left != '0) |=> (len_left == $past(len_left) - 1'b1));
    p_budget_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !load |-> (LW'(tx_used) <= tx_budget && LW'(rx_used) <= rx_budget));
endmodule

// File: rtl/pk_word_packer.sv
module pk_word_packer
    import pk_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int LW    = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wide_mode,
    input  logic          len_wr,
    input  logic [LW-1:0] len_val,
    input  logic          clr_tx,
    input  logic          clr_rx,
    input  logic          port_wr,
    input  logic [31:0]   port_wdata,
    input  logic          port_rd,
    output logic [31:0]   port_rdata,
    output logic          tx_avail,
    output logic [7:0]    tx_byte,
    input  logic          tx_take,
    input  logic          rx_push,
    input  logic [7:0]    rx_byte,
    output logic          rx_room,
    output logic          tx_dreq,
    output logic          rx_dreq,
    output logic [LW-1:0] len_left,
    output logic          done
);
    localparam int CW = $clog2(DEPTH) + 1;

    typedef struct packed {
        logic wide;
    } top_st_t;

    top_st_t st_d, st_q;

    logic [CW-1:0]           tx_cnt, rx_cnt;
    logic [0:0][7:0]         tx_peek;
    logic [LANES-1:0][7:0]   rx_peek;
    logic [LANES-1:0][7:0]   wr_lanes;
    logic [0:0][7:0]         rx_lane;
    logic [LW-1:0]           tx_budget, rx_budget;
    logic                    mode_flip, tx_flush, rx_flush, rx_accept;
    logic [2:0]              tx_want, tx_push_n, tx_pop_n, rx_push_n;
    logic [2:0]              rx_avail_n, rx_pop_n, tx_used, rx_used;
    int                      tx_free;

    always_comb begin
        st_d      = st_q;
        st_d.wide = wide_mode;

        mode_flip = (wide_mode != st_q.wide);
        tx_flush  = clr_tx | mode_flip;
        rx_flush  = clr_rx | mode_flip;

        tx_free   = DEPTH - int'(tx_cnt);
        tx_want   = wide_mode ? lane_cap(int'(tx_budget)) : 3'd1;
        tx_push_n = (port_wr && !tx_flush && tx_want != 3'd0 && int'(tx_want) <= tx_free)
                    ? tx_want : 3'd0;
        tx_pop_n  = (tx_take && tx_cnt != '0 && !tx_flush) ? 3'd1 : 3'd0;

        rx_accept = rx_push && (int'(rx_cnt) < DEPTH) && !rx_flush;
        rx_push_n = {2'b00, rx_accept};

        if (wide_mode)
            rx_avail_n = lane_cap((int'(rx_budget) < int'(rx_cnt)) ? int'(rx_budget) : int'(rx_cnt));
        else
            rx_avail_n = (rx_cnt != '0) ? 3'd1 : 3'd0;
        rx_pop_n = (port_rd && !rx_flush) ? rx_avail_n : 3'd0;

        for (int i = 0; i < LANES; i++) begin
            wr_lanes[i]         = port_wdata[8*i +: 8];
            port_rdata[8*i +: 8] = (3'(i) < rx_avail_n) ? rx_peek[i] : 8'h00;
        end
        rx_lane[0] = rx_byte;

        tx_used = wide_mode ? tx_push_n : 3'd0;
        rx_used = wide_mode ? rx_pop_n  : 3'd0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    pk_lane_fifo #(.DEPTH(DEPTH), .IN_LANES(LANES), .OUT_LANES(1)) u_txq (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (tx_flush),
        .push_n    (tx_push_n),
        .push_data (wr_lanes),
        .pop_n     (tx_pop_n),
        .peek      (tx_peek),
        .count     (tx_cnt)
    );

    pk_lane_fifo #(.DEPTH(DEPTH), .IN_LANES(1), .OUT_LANES(LANES)) u_rxq (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (rx_flush),
        .push_n    (rx_push_n),
        .push_data (rx_lane),
        .pop_n     (rx_pop_n),
        .peek      (rx_peek),
        .count     (rx_cnt)
    );

    pk_len_track #(.LW(LW)) u_len (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (len_wr),
        .load_val  (len_val),
        .byte_done (rx_accept),
        .tx_used   (tx_used),
        .rx_used   (rx_used),
        .len_left  (len_left),
        .tx_budget (tx_budget),
        .rx_budget (rx_budget)
    );

    assign tx_avail = (tx_cnt != '0);
    assign tx_byte  = tx_peek[0];
    assign rx_room  = (int'(rx_cnt) < DEPTH);
    assign done     = (len_left == '0) && (tx_cnt == '0);
    assign tx_dreq  = wide_mode && (tx_budget != '0) && (tx_free >= LANES);
    assign rx_dreq  = wide_mode && (rx_budget != '0) &&
                      (int'(rx_cnt) >= int'(lane_cap(int'(rx_budget))));

    p_mode_flush_r9: assert property (@(posedge clk) disable iff (!rst_n)
        mode_flip |=> !tx_avail);
    p_rx_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_push && !rx_room && !len_wr) |=> $stable(len_left));
    p_done_tx_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !port_wr && !len_wr) |=> done);
    p_narrow_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !wide_mode |-> (!tx_dreq && !rx_dreq));
endmodule

// File: tb/sim_pk_word_packer.sv
module sim_pk_word_packer;
    logic        clk = 0;
    logic        rst_n = 0;
    logic        wide_mode = 0, len_wr = 0, clr_tx = 0, clr_rx = 0;
    logic [15:0] len_val = 0;
    logic        port_wr = 0, port_rd = 0, tx_take = 0, rx_push = 0;
    logic [31:0] port_wdata = 0;
    logic [7:0]  rx_byte = 0;
    logic [31:0] port_rdata;
    logic        tx_avail, rx_room, tx_dreq, rx_dreq, done;
    logic [7:0]  tx_byte;
    logic [15:0] len_left;

    int n_chk = 0, n_bad = 0;
    bit finished = 0;
    logic [7:0] exp_q [$];

    always #5 clk = ~clk;

    pk_word_packer u0 (
        .clk(clk), .rst_n(rst_n), .wide_mode(wide_mode), .len_wr(len_wr),
        .len_val(len_val), .clr_tx(clr_tx), .clr_rx(clr_rx), .port_wr(port_wr),
        .port_wdata(port_wdata), .port_rd(port_rd), .port_rdata(port_rdata),
        .tx_avail(tx_avail), .tx_byte(tx_byte), .tx_take(tx_take),
        .rx_push(rx_push), .rx_byte(rx_byte), .rx_room(rx_room),
        .tx_dreq(tx_dreq), .rx_dreq(rx_dreq), .len_left(len_left), .done(done)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic load_len(input logic [15:0] v);
        len_wr = 1; len_val = v; tick(); len_wr = 0;
    endtask

    // driver: writes a word and records the bytes expected to be queued
    task automatic wr_word(input logic [31:0] d, input int nexp);
        port_wr = 1; port_wdata = d; tick(); port_wr = 0;
        for (int i = 0; i < nexp; i++) exp_q.push_back(d[8*i +: 8]);
    endtask

    // monitor side: take bytes and compare against the scoreboard
    task automatic drain(input string req);
        while (exp_q.size() != 0) begin
            check(req, {31'b0, tx_avail}, 32'd1);
            check(req, {24'b0, tx_byte}, {24'b0, exp_q.pop_front()});
            tx_take = 1; tick(); tx_take = 0;
        end
        check(req, {31'b0, tx_avail}, 32'd0);
    endtask

    task automatic push_rx(input logic [7:0] b);
        rx_push = 1; rx_byte = b; tick(); rx_push = 0;
    endtask

    task automatic read_port();
        port_rd = 1; tick(); port_rd = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_bad++; n_chk++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        tick(); tick();
        rst_n = 1;
        tick();
        // R1 reset state
        check("R1 len", {16'b0, len_left}, 32'd0);
        check("R1 done", {31'b0, done}, 32'd1);
        check("R1 tx_avail", {31'b0, tx_avail}, 32'd0);
        check("R1 rx_room", {31'b0, rx_room}, 32'd1);
        check("R1 dreq", {30'b0, tx_dreq, rx_dreq}, 32'd0);
        check("R1 rdata", port_rdata, 32'd0);

        // R2 byte mode
        wr_word(32'h123456AB, 1);
        wr_word(32'hFFFFFFCD, 1);
        drain("R2 narrow tx");
        push_rx(8'h11);
        push_rx(8'h22);
        check("R6 saturate at zero", {16'b0, len_left}, 32'd0);
        check("R2 rdata first", port_rdata, 32'h00000011);
        read_port();
        check("R2 rdata second", port_rdata, 32'h00000022);
        read_port();
        check("R2 rdata empty", port_rdata, 32'h0);

        // R9 mode change flushes
        wr_word(32'h5A, 0);
        check("R9 byte queued", {31'b0, tx_avail}, 32'd1);
        wide_mode = 1; tick();
        check("R9 mode flush", {31'b0, tx_avail}, 32'd0);

        // R3 / R7 / R8 word mode, length 6
        load_len(16'd6);
        check("R6 load", {16'b0, len_left}, 32'd6);
        check("R7 not done", {31'b0, done}, 32'd0);
        check("R8 tx_dreq up", {31'b0, tx_dreq}, 32'd1);
        check("R8 rx_dreq idle", {31'b0, rx_dreq}, 32'd0);
        wr_word(32'h44332211, 4);
        wr_word(32'hDDCCBBAA, 2);
        check("R8 tx_dreq budget spent", {31'b0, tx_dreq}, 32'd0);
        wr_word(32'hFFFFFFFF, 0);
        drain("R3 wide unpack");

        // R4 / R6 / R8 receive packing
        push_rx(8'h50); push_rx(8'h51); push_rx(8'h52);
        check("R8 rx_dreq partial", {31'b0, rx_dreq}, 32'd0);
        push_rx(8'h53);
        check("R8 rx_dreq word", {31'b0, rx_dreq}, 32'd1);
        check("R6 count down", {16'b0, len_left}, 32'd2);
        check("R4 packed word", port_rdata, 32'h53525150);
        read_port();
        check("R8 rx_dreq emptied", {31'b0, rx_dreq}, 32'd0);
        push_rx(8'h54);
        check("R7 not done yet", {31'b0, done}, 32'd0);
        push_rx(8'h55);
        check("R8 rx_dreq tail", {31'b0, rx_dreq}, 32'd1);
        check("R4 tail zero padded", port_rdata, 32'h00005554);
        check("R7 done", {31'b0, done}, 32'd1);
        read_port();
        check("R4 tail popped", port_rdata, 32'h0);

        // R5 overflow
        load_len(16'd40);
        for (int w = 0; w < 4; w++) wr_word(32'h03020100 + 32'h04040404 * w, 4);
        check("R8 tx_dreq full", {31'b0, tx_dreq}, 32'd0);
        wr_word(32'hEEEEEEEE, 0);
        drain("R5 tx overflow drop");
        for (int b = 0; b < 16; b++) push_rx(8'(b));
        check("R5 rx full", {31'b0, rx_room}, 32'd0);
        check("R6 len after 16", {16'b0, len_left}, 32'd24);
        push_rx(8'hEE);
        check("R5 rx drop keeps len", {16'b0, len_left}, 32'd24);
        clr_rx = 1; tick(); clr_rx = 0;
        check("R9 clr_rx", {31'b0, rx_room}, 32'd1);
        check("R9 clr_rx rdata", port_rdata, 32'h0);

        // R10 concurrent write and take
        load_len(16'd60);
        wr_word(32'h13121110, 4);
        check("R10 head", {24'b0, tx_byte}, {24'b0, exp_q[0]});
        void'(exp_q.pop_front());
        port_wr = 1; port_wdata = 32'h17161514; tx_take = 1; tick();
        port_wr = 0; tx_take = 0;
        for (int i = 0; i < 4; i++) exp_q.push_back(8'h14 + 8'(i));
        drain("R10 write with take");
        for (int w = 0; w < 4; w++) wr_word(32'h23222120 + 32'h04040404 * w, 4);
        void'(exp_q.pop_front());
        port_wr = 1; port_wdata = 32'h99999999; tx_take = 1; tick();
        port_wr = 0; tx_take = 0;
        drain("R10 full write with take");

        // R10 concurrent push and read
        push_rx(8'h60); push_rx(8'h61); push_rx(8'h62); push_rx(8'h63);
        check("R10 rx word", port_rdata, 32'h63626160);
        port_rd = 1; rx_push = 1; rx_byte = 8'h64; tick();
        port_rd = 0; rx_push = 0;
        check("R10 push with read", port_rdata, 32'h00000064);

        // R9 write dropped by same-cycle flush
        port_wr = 1; port_wdata = 32'h77777777; clr_tx = 1; tick();
        port_wr = 0; clr_tx = 0;
        check("R9 write with flush", {31'b0, tx_avail}, 32'd0);

        // R6 load beats decrement
        clr_rx = 1; tick(); clr_rx = 0;
        len_wr = 1; len_val = 16'd9; rx_push = 1; rx_byte = 8'h70; tick();
        len_wr = 0; rx_push = 0;
        check("R6 load priority", {16'b0, len_left}, 32'd9);

        // return to idle
        len_wr = 1; len_val = 16'd0; clr_tx = 1; clr_rx = 1; tick();
        len_wr = 0; clr_tx = 0; clr_rx = 0;
        check("R7 idle done", {31'b0, done}, 32'd1);
        check("R8 idle dreq", {30'b0, tx_dreq, rx_dreq}, 32'd0);
        check("R9 idle rdata", port_rdata, 32'h0);

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule